// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two IEEE-754 operands under one of sixteen predicate codes and writes the one-bit outcome into a selected bit of an 8-bit condition vector. It accepts single precision, double precision and paired-single operands. A paired-single compare evaluates two 32-bit lanes in the same cycle and writes two adjacent condition bits. An absolute-value option clears the sign bit of every operand before the comparison. The unit performs no arithmetic. NaN detection works on the raw bits, and ordering is sign-magnitude ordering of the raw patterns.

All the compare logic is combinational. A request is presented with `valid_i` high for one clock. The condition vector and the invalid-operation flag are registered on that edge, so the result appears on the outputs in the following cycle. A host pipeline keeps the condition vector here and reads it back to resolve branches or conditional moves.

Top module: `fcmp_cond_unit`

## Requirements
- R1: After reset `cc_o` is 8'h00 and `invalid_o` is 0.
- R2: For codes 0 to 7, bit 0 of `pred_i` selects "unordered", bit 1 selects "equal" and bit 2 selects "a less than b". The result is the OR of the selected terms. Equal and less are false whenever either operand is a NaN.
- R3: Codes 8 to 15 (bit 3 set) give the same truth function as the code with bit 3 cleared.
- R4: A NaN has an all-ones exponent and a nonzero fraction. It is signaling when the top fraction bit is 1. For codes 0 to 7, `invalid_o` is 1 only when an operand is a signaling NaN.
- R5: For codes 8 to 15, `invalid_o` is 1 when either operand is any NaN. Infinity is not a NaN.
- R6: Codes 0 and 8 always write 0 and still raise `invalid_o` by the rule for their group.
- R7: +0 equals -0. Negative values order below positive values, and a larger magnitude is lower among negative values.
- R8: With `abs_i` = 1 the sign bit of each operand (bit 63 for double, bit 31 of each single lane) is cleared before the compare.
- R9: `fmt_i` 0 = single, using bits 31:0 only. 1 = double, using all 64 bits. 2 = paired-single. 3 leaves the state unchanged, with `invalid_o` = 0.
- R10: Paired-single compares bits 31:0 into `cc_o[cc_idx_i]` and bits 63:32 into `cc_o[cc_idx_i+1]`. `invalid_o` is the OR of the two lanes' invalid flags.
- R11: A paired-single request with an odd `cc_idx_i` leaves `cc_o` unchanged, with `invalid_o` = 0.
- R12: A request writes only its target bit or bits, and the result is visible the cycle after the strobe. Without `valid_i` the vector holds and `invalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Compare request strobe |
| fmt_i | input | 2 | Operand format (0 single, 1 double, 2 paired-single) |
| pred_i | input | 4 | Predicate code |
| abs_i | input | 1 | Compare magnitudes only |
| cc_idx_i | input | 3 | Target condition bit |
| op_a_i | input | 64 | Left operand |
| op_b_i | input | 64 | Right operand |
| cc_o | output | 8 | Condition vector |
| invalid_o | output | 1 | Invalid-operation flag of the last request |

## Verification
The hardest case to reach is a paired-single request where the two lanes disagree: one lane holds a NaN and the other is ordered, or the two lanes give opposite answers. Only this case separates a correct lane-to-bit mapping from a swapped one. It also shows whether the lane invalid flags are merged. The vector table builds such operands by packing different single values into the two halves of each operand. It then follows them with odd-index and reserved-format requests, and the model checks that these leave every previously written bit intact.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    parameter int SP_EXP_W  = 8;
    parameter int SP_FRAC_W = 23;
    parameter int DP_EXP_W  = 11;
    parameter int DP_FRAC_W = 52;
    parameter int CC_W      = 8;
    parameter int IDX_W     = $clog2(CC_W);

    typedef enum logic [1:0] {
        FMT_SP  = 2'd0,
        FMT_DP  = 2'd1,
        FMT_PS  = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [CC_W-1:0] cc;
        logic            inv;
    } cc_state_t;
endpackage

// File: rtl/fcmp_lane.sv
module fcmp_lane #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         abs_i,
    output logic         unord_o,
    output logic         eq_o,
    output logic         lt_o,
    output logic         any_nan_o,
    output logic         sig_nan_o
);
    logic         sa, sb;
    logic [W-2:0] ma, mb;
    logic         nan_a, nan_b, both_zero;

    always_comb begin
        sa        = a_i[W-1] & ~abs_i;
        sb        = b_i[W-1] & ~abs_i;
        ma        = a_i[W-2:0];
        mb        = b_i[W-2:0];
        nan_a     = (&ma[W-2:FRAC_W]) && (ma[FRAC_W-1:0] != '0);
        nan_b     = (&mb[W-2:FRAC_W]) && (mb[FRAC_W-1:0] != '0);
        any_nan_o = nan_a | nan_b;
        sig_nan_o = (nan_a & ma[FRAC_W-1]) | (nan_b & mb[FRAC_W-1]);
        unord_o   = any_nan_o;
        both_zero = (ma == '0) && (mb == '0);
        eq_o      = ~any_nan_o && (both_zero || ((sa == sb) && (ma == mb)));
        lt_o      = 1'b0;
        if (!any_nan_o && !both_zero) begin
            case ({sa, sb})
                2'b10:   lt_o = 1'b1;
                2'b01:   lt_o = 1'b0;
                2'b00:   lt_o = ma < mb;
                default: lt_o = ma > mb;
            endcase
        end
    end
endmodule

// File: rtl/fcmp_pred.sv
module fcmp_pred (
    input  logic [3:0] pred_i,
    input  logic       unord_i,
    input  logic       eq_i,
    input  logic       lt_i,
    input  logic       any_nan_i,
    input  logic       sig_nan_i,
    output logic       res_o,
    output logic       inv_o
);
    always_comb begin
        res_o = (pred_i[0] & unord_i)
              | (pred_i[1] & eq_i & ~unord_i)
              | (pred_i[2] & lt_i & ~unord_i);
        inv_o = pred_i[3] ? any_nan_i : sig_nan_i;
    end
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
    import fcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_i,
    input  logic [1:0]  fmt_i,
    input  logic [3:0]  pred_i,
    input  logic        abs_i,
    input  logic [2:0]  cc_idx_i,
    input  logic [63:0] op_a_i,
    input  logic [63:0] op_b_i,
    output logic [7:0]  cc_o,
    output logic        invalid_o
);
    localparam int SP_W  = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int DP_W  = 1 + DP_EXP_W + DP_FRAC_W;
    localparam int LANES = 2;

    logic [LANES-1:0] sp_res, sp_inv;
    logic             dp_res, dp_inv;
    cc_state_t        st_d, st_q;

    // Two single lanes: lane 0 is bits 31:0, lane 1 is bits 63:32
    for (genvar g = 0; g < LANES; g++) begin : g_sp
        logic unord, eq, lt, anan, snan;
        fcmp_lane #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_lane (
            .a_i(op_a_i[g*SP_W +: SP_W]), .b_i(op_b_i[g*SP_W +: SP_W]),
            .abs_i(abs_i), .unord_o(unord), .eq_o(eq), .lt_o(lt),
            .any_nan_o(anan), .sig_nan_o(snan)
        );
        fcmp_pred u_pred (
            .pred_i(pred_i), .unord_i(unord), .eq_i(eq), .lt_i(lt),
            .any_nan_i(anan), .sig_nan_i(snan),
            .res_o(sp_res[g]), .inv_o(sp_inv[g])
        );
    end

    logic dp_unord, dp_eq, dp_lt, dp_anan, dp_snan;
    fcmp_lane #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp_lane (
        .a_i(op_a_i[DP_W-1:0]), .b_i(op_b_i[DP_W-1:0]), .abs_i(abs_i),
        .unord_o(dp_unord), .eq_o(dp_eq), .lt_o(dp_lt),
        .any_nan_o(dp_anan), .sig_nan_o(dp_snan)
    );
    fcmp_pred u_dp_pred (
        .pred_i(pred_i), .unord_i(dp_unord), .eq_i(dp_eq), .lt_i(dp_lt),
        .any_nan_i(dp_anan), .sig_nan_i(dp_snan),
        .res_o(dp_res), .inv_o(dp_inv)
    );

    always_comb begin
        st_d     = st_q;
        st_d.inv = 1'b0;
        if (valid_i) begin
            case (fmt_e'(fmt_i))
                FMT_SP: begin
                    st_d.cc[cc_idx_i] = sp_res[0];
                    st_d.inv          = sp_inv[0];
                end
                FMT_DP: begin
                    st_d.cc[cc_idx_i] = dp_res;
                    st_d.inv          = dp_inv;
                end
                FMT_PS: begin
                    if (!cc_idx_i[0]) begin
                        st_d.cc[cc_idx_i]        = sp_res[0];
                        st_d.cc[cc_idx_i | 3'd1] = sp_res[1];
                        st_d.inv                 = |sp_inv;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cc_o      = st_q.cc;
    assign invalid_o = st_q.inv;
endmodule

// File: rtl/fcmp_cond_unit_chk.sv
module fcmp_cond_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [1:0]  fmt_i,
    input logic [3:0]  pred_i,
    input logic        abs_i,
    input logic [2:0]  cc_idx_i,
    input logic [63:0] op_a_i,
    input logic [63:0] op_b_i,
    input logic [7:0]  cc_o,
    input logic        invalid_o
);
    logic a_nan_sp, b_nan_sp;
    assign a_nan_sp = (op_a_i[30:23] == 8'hFF) && (op_a_i[22:0] != 23'd0);
    assign b_nan_sp = (op_b_i[30:23] == 8'hFF) && (op_b_i[22:0] != 23'd0);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(cc_o) && !invalid_o));

    p_ps_odd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && fmt_i == 2'd2 && cc_idx_i[0]) |=> ($stable(cc_o) && !invalid_o));

    p_rsv_fmt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && fmt_i == 2'd3) |=> $stable(cc_o));

    p_one_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && fmt_i[1] == 1'b0) |=> ($countones(cc_o ^ $past(cc_o)) <= 1));

    p_false_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && fmt_i == 2'd0 && pred_i[2:0] == 3'd0) |=> (cc_o[$past(cc_idx_i)] == 1'b0));

    p_sig_grp_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && fmt_i == 2'd0 && pred_i[3] && (a_nan_sp || b_nan_sp)) |=> invalid_o);
endmodule

bind fcmp_cond_unit fcmp_cond_unit_chk u_chk (.*);

// File: tb/sim_fcmp_cond_unit.sv
module sim_fcmp_cond_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  fmt_i = '0;
    logic [3:0]  pred_i = '0;
    logic        abs_i = 1'b0;
    logic [2:0]  cc_idx_i = '0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic [7:0]  cc_o;
    logic        invalid_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fcmp_cond_unit u0 (.*);

    typedef struct packed {
        logic [1:0]  fmt;
        logic [3:0]  pred;
        logic        abs_f;
        logic [2:0]  idx;
        logic [63:0] a;
        logic [63:0] b;
        logic        lo;
        logic        hi;
        logic        inv;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] S1 = 32'h3F80_0000, S2 = 32'h4000_0000;
    localparam logic [31:0] SN1 = 32'hBF80_0000, SN2 = 32'hC000_0000;
    localparam logic [31:0] SQN = 32'h7F80_0001, SSN = 32'h7FC0_0000, SINF = 32'h7F80_0000;
    localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000, D2 = 64'h4000_0000_0000_0000;
    localparam logic [63:0] DQN = 64'h7FF0_0000_0000_0001, DN2 = 64'hC000_0000_0000_0000;
    localparam int NV = 28;

    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd4,  1'b0, 3'd0, {32'd0, S1},  {32'd0, S2},  1'b1, 1'b0, 1'b0, 4'd2},  // R2 olt
        '{2'd0, 4'd4,  1'b0, 3'd1, {32'd0, S2},  {32'd0, S1},  1'b0, 1'b0, 1'b0, 4'd2},  // R2
        '{2'd0, 4'd2,  1'b0, 3'd2, {32'd0, S1},  {32'd0, S1},  1'b1, 1'b0, 1'b0, 4'd2},  // R2 eq
        '{2'd0, 4'd2,  1'b0, 3'd3, 64'd0, {32'd0, 32'h8000_0000}, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 zeros
        '{2'd0, 4'd4,  1'b0, 3'd4, {32'd0, SN2}, {32'd0, SN1}, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 negatives
        '{2'd0, 4'd4,  1'b0, 3'd5, {32'd0, SN1}, {32'd0, SN2}, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{2'd0, 4'd1,  1'b0, 3'd6, {32'd0, SQN}, {32'd0, S1},  1'b1, 1'b0, 1'b0, 4'd4},  // R4 quiet
        '{2'd0, 4'd3,  1'b0, 3'd7, {32'd0, SSN}, {32'd0, S1},  1'b1, 1'b0, 1'b1, 4'd4},  // R4 signaling
        '{2'd0, 4'd4,  1'b0, 3'd0, {32'd0, SQN}, {32'd0, S1},  1'b0, 1'b0, 1'b0, 4'd2},  // R2 ordered
        '{2'd0, 4'd12, 1'b0, 3'd1, {32'd0, SQN}, {32'd0, S1},  1'b0, 1'b0, 1'b1, 4'd5},  // R5
        '{2'd0, 4'd13, 1'b0, 3'd2, {32'd0, S1},  {32'd0, SQN}, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 nge
        '{2'd0, 4'd0,  1'b0, 3'd3, {32'd0, SSN}, {32'd0, S1},  1'b0, 1'b0, 1'b1, 4'd6},  // R6 f
        '{2'd0, 4'd8,  1'b0, 3'd4, {32'd0, SQN}, {32'd0, SQN}, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 sf
        '{2'd0, 4'd6,  1'b0, 3'd5, {32'd0, S1},  {32'd0, S1},  1'b1, 1'b0, 1'b0, 4'd2},  // R2 ole
        '{2'd0, 4'd7,  1'b0, 3'd6, {32'd0, S2},  {32'd0, S1},  1'b0, 1'b0, 1'b0, 4'd2},  // R2 ule
        '{2'd0, 4'd5,  1'b1, 3'd6, {32'd0, SN1}, {32'd0, SN2}, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
        '{2'd0, 4'd10, 1'b1, 3'd0, {32'd0, S1},  {32'd0, SN1}, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 seq
        '{2'd0, 4'd4,  1'b0, 3'd7, {32'd0, S1},  {32'd0, SINF},1'b1, 1'b0, 1'b0, 4'd5},  // R5 inf
        '{2'd1, 4'd4,  1'b0, 3'd1, D1, D2,                     1'b1, 1'b0, 1'b0, 4'd9},  // R9 double
        '{2'd1, 4'd2,  1'b0, 3'd2, 64'h8000_0000_0000_0000, 64'd0, 1'b1, 1'b0, 1'b0, 4'd9}, // R9
        '{2'd1, 4'd9,  1'b0, 3'd3, DQN, D1,                    1'b1, 1'b0, 1'b1, 4'd3},  // R3 ngle
        '{2'd1, 4'd4,  1'b1, 3'd4, DN2, D1,                    1'b0, 1'b0, 1'b0, 4'd8},  // R8 double
        '{2'd0, 4'd2,  1'b0, 3'd5, {32'hFFFF_FFFF, S1}, {32'd0, S1}, 1'b1, 1'b0, 1'b0, 4'd9}, // R9 low only
        '{2'd2, 4'd4,  1'b0, 3'd0, {S2, S1},  {S1, S2},        1'b1, 1'b0, 1'b0, 4'd10}, // R10
        '{2'd2, 4'd12, 1'b0, 3'd6, {SQN, S1}, {S1, S1},        1'b0, 1'b0, 1'b1, 4'd10}, // R10 inv merge
        '{2'd2, 4'd2,  1'b0, 3'd3, {S1, S1},  {S1, S1},        1'b0, 1'b0, 1'b0, 4'd11}, // R11 odd
        '{2'd3, 4'd2,  1'b0, 3'd2, {S2, S2},  {S1, S1},        1'b0, 1'b0, 1'b0, 4'd9},  // R9 reserved
        '{2'd2, 4'd2,  1'b1, 3'd4, {SN1, S1}, {S1, SN1},       1'b1, 1'b1, 1'b0, 4'd10}  // R10 abs
    };

    task automatic check(input string tag, input logic [7:0] acc, input logic [7:0] ecc,
                         input logic ainv, input logic einv);
        checks++;
        if (acc !== ecc || ainv !== einv) begin
            errors++;
            $display("FAIL %s: cc=%h inv=%b expected cc=%h inv=%b", tag, acc, ainv, ecc, einv);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] exp_cc;
        repeat (3) @(negedge clk);
        check("R1 reset", cc_o, 8'h00, invalid_o, 1'b0);
        rst_n = 1'b1;
        exp_cc = 8'h00;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            valid_i  = 1'b1;
            fmt_i    = VECS[i].fmt;
            pred_i   = VECS[i].pred;
            abs_i    = VECS[i].abs_f;
            cc_idx_i = VECS[i].idx;
            op_a_i   = VECS[i].a;
            op_b_i   = VECS[i].b;
            if (VECS[i].fmt == 2'd0 || VECS[i].fmt == 2'd1) begin
                exp_cc[VECS[i].idx] = VECS[i].lo;
            end else if (VECS[i].fmt == 2'd2 && !VECS[i].idx[0]) begin
                exp_cc[VECS[i].idx]        = VECS[i].lo;
                exp_cc[VECS[i].idx + 3'd1] = VECS[i].hi;
            end
            @(negedge clk);
            valid_i = 1'b0;
            check($sformatf("R%0d vector %0d", VECS[i].req, i), cc_o, exp_cc, invalid_o, VECS[i].inv);
        end
        // R12: inputs change without strobe; vector holds, invalid drops
        fmt_i = 2'd0; pred_i = 4'd12; cc_idx_i = 3'd0;
        op_a_i = {32'd0, SSN}; op_b_i = {32'd0, SSN};
        repeat (3) @(negedge clk);
        check("R12 idle hold", cc_o, exp_cc, invalid_o, 1'b0);
        // R12: single write touches only its bit
        valid_i = 1'b1; fmt_i = 2'd0; pred_i = 4'd7; cc_idx_i = 3'd5;
        op_a_i = {32'd0, S2}; op_b_i = {32'd0, S1};
        exp_cc[5] = 1'b0;
        @(negedge clk);
        valid_i = 1'b0;
        check("R12 single bit", cc_o, exp_cc, invalid_o, 1'b0);
        // R1: reset in mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", cc_o, 8'h00, invalid_o, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule